// File: doc/BRIEF.md
# CAVLC Trailing-One Sign and Level Decoder

This block sits in a residual-coefficient entropy decoder right after the stage that resolves the total count of nonzero coefficients and the number of trailing ±1 coefficients. It is given that count, the trailing-one count, the largest number of coefficients the block kind can hold, and an aligned 32-bit window of the bitstream that starts just after the coefficient-token codeword. It first resolves every trailing-one sign in a single cycle. It then decodes the remaining nonzero levels, one per cycle, with the adaptive suffix length.

Each result goes out as a write to an external level buffer, indexed in decode order. In the sign cycle up to three entries are written at once. Every cycle the block reports how many window bits it consumed, so that the external bitstream shifter can realign the window for the next cycle. In the cycle of its last write the block raises a one-cycle done strobe. With that strobe it reports whether the later total-zeros stage may be skipped, and it flags a block that has no coefficients at all.

The level prefix is found by a leading-one search over the top 16 window bits. A prefix of 15 selects the escape form, which has a 12-bit suffix.

Top module: `cavlc_level_dec`

## Requirements
- R1: While reset is held and after it is released with no start, the block writes nothing, consumes 0 bits and holds done, skip_tz and zero_blk low.
- R2: A start with total_coeff = 0 gives, in the next cycle, done = 1, zero_blk = 1 and skip_tz = 1, with no writes and 0 bits consumed.
- R3: In the cycle after a start with total_coeff > 0, the window's top three bits (sampled at start) act as sign bits, MSB for the first trailing one. Only the first trailing_ones of them are used, and the rest are ignored. A sign bit 0 writes +1 and a sign bit 1 writes -1. The entries go to indices 0, 1, 2 on wr_data lanes 0, 1, 2 (lane k is bits 16k+15..16k), with wr_en bit k set for each lane written. consume_len equals trailing_ones.
- R4: Each remaining level takes exactly one cycle. That cycle has wr_en = 001, and wr_idx continues from trailing_ones upward in decode order. consume_len equals the codeword length, which is the prefix + 1 + the suffix size.
- R5: The prefix is the count of leading zeros before the first 1. The level code is (prefix << suffixLength) + suffix. An even code c yields (c+2)/2, and an odd code c yields -(c+1)/2.
- R6: A prefix of 14 while suffixLength is 0 carries a 4-bit suffix, giving a 19-bit codeword.
- R7: A prefix of 15 is an escape with a 12-bit suffix and a 28-bit codeword. When suffixLength is 0, 15 is added to the level code.
- R8: When trailing_ones < 3, the first level decoded after the signs has 2 added to its level code, which raises its magnitude by one.
- R9: suffixLength starts at 1 if total_coeff > 10 and trailing_ones < 3, and at 0 otherwise. After each level it becomes 1 if it was 0. It then grows by one when the magnitude exceeds 3 << (suffixLength-1), and it never exceeds 6.
- R10: done is a one-cycle pulse in the cycle of the final write (the sign cycle when total_coeff = trailing_ones). With done, skip_tz is 1 exactly when total_coeff is 0 or equals max_coeff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin one block; sampled only when idle |
| total_coeff | input | 5 | Count of nonzero coefficients (0..16) |
| trailing_ones | input | 2 | Count of trailing ±1 coefficients (0..3) |
| max_coeff | input | 5 | Coefficient capacity of this block kind |
| bits | input | 32 | Aligned bitstream window, first bit at bit 31 |
| consume_len | output | 6 | Bits consumed from the window this cycle |
| wr_en | output | 3 | Per-lane level buffer write enables |
| wr_idx | output | 4 | Buffer index for lane 0; lane k writes wr_idx+k |
| wr_data | output | 48 | Three signed 16-bit level lanes |
| done | output | 1 | Final write of the block this cycle |
| skip_tz | output | 1 | With done: total-zeros stage not needed |
| zero_blk | output | 1 | With done: block has no coefficients |

## Verification
The escape codeword that occurs while the suffix length is still 0 is the hardest case to reach from the ports. It needs a first level large enough, after the magnitude bump, to overflow the 4-bit suffix of the prefix-14 form. The suffix-length cap is also hard to reach, since it needs a run of levels that push the length up five times. The bench reaches both with its own encoder. That encoder builds each stream from chosen level values by the forward coding rules and tracks the suffix length as the coder would. It then replays the stream through a window shifter driven by consume_len, so a wrong length or a wrong suffix-length update shows up as garbled later levels.

// File: rtl/cavlc_lvl_pkg.sv
package cavlc_lvl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ZERO  = 2'd1,
    ST_SIGN  = 2'd2,
    ST_LEVEL = 2'd3
  } seq_state_e;

  localparam int unsigned SL_W    = 3;   // suffix length register width
  localparam int unsigned SL_CAP  = 6;   // largest suffix length
  localparam int unsigned PFX_W   = 4;   // prefix count width
  localparam int unsigned ESC_PFX = 15;  // prefix value that selects the escape form
  localparam int unsigned ESC_SUF = 12;  // escape suffix bits
  localparam int unsigned ESC_LEN = 28;  // escape codeword length
  localparam int unsigned T1_MAX  = 3;   // trailing ones per block

endpackage

// File: rtl/t1_sign_unit.sv
module t1_sign_unit
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned LVL_W = 16
) (
  input  logic [T1_MAX-1:0]       sign_i,
  input  logic [1:0]              t1_i,
  output logic [T1_MAX-1:0]       we_o,
  output logic [T1_MAX*LVL_W-1:0] data_o
);

  // Lane k carries the k-th trailing one; its sign bit sits k places below the MSB.
  for (genvar k = 0; k < T1_MAX; k++) begin : g_lane
    assign we_o[k] = (t1_i > 2'(k));
    assign data_o[k*LVL_W +: LVL_W] = sign_i[T1_MAX-1-k] ? {LVL_W{1'b1}} : LVL_W'(1);
  end

endmodule

// File: rtl/level_code_unit.sv
module level_code_unit
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned WIN_W = 32,
  parameter int unsigned LVL_W = 16,
  parameter int unsigned LEN_W = 6
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [SL_W-1:0]  sl_i,
  input  logic             bump_i,
  output logic [LVL_W-1:0] level_o,
  output logic [LEN_W-1:0] len_o,
  output logic [SL_W-1:0]  sl_next_o
);

  localparam int unsigned LC_W = ESC_SUF + 2;
  localparam logic [PFX_W-1:0] PFX_ESC = PFX_W'(ESC_PFX);
  localparam logic [PFX_W-1:0] PFX_14  = PFX_W'(ESC_PFX - 1);
  localparam logic [PFX_W:0]   SUF_ESC = (PFX_W+1)'(ESC_SUF);

  logic [PFX_W-1:0]   pfx;
  logic               found;
  logic [PFX_W:0]     suf_sz;
  logic [WIN_W-1:0]   after_pfx;
  logic [ESC_SUF-1:0] suf_top;
  logic [ESC_SUF-1:0] suf;
  logic [LC_W-1:0]    lc;
  logic [LC_W-1:0]    mag;
  logic [LC_W-1:0]    thr;
  logic [SL_W-1:0]    sl_eff;

  // Leading-one search over the prefix field
  always_comb begin
    found = 1'b0;
    pfx   = PFX_ESC;
    for (int i = 0; i <= int'(ESC_PFX); i++) begin
      if (!found && win_i[WIN_W-1-i]) begin
        pfx   = PFX_W'(i);
        found = 1'b1;
      end
    end
  end

  // Suffix size, suffix extraction and code length
  always_comb begin
    if (pfx == PFX_ESC)                 suf_sz = SUF_ESC;
    else if (pfx == PFX_14 && sl_i == '0) suf_sz = (PFX_W+1)'(4);
    else                                suf_sz = (PFX_W+1)'(sl_i);
    after_pfx = win_i << ({1'b0, pfx} + (PFX_W+1)'(1));
    suf_top   = after_pfx[WIN_W-1 -: ESC_SUF];
    suf       = suf_top >> (SUF_ESC - suf_sz);
    len_o     = LEN_W'(pfx) + LEN_W'(1) + LEN_W'(suf_sz);
    if (pfx == PFX_ESC) begin
      assert_esc_len_R7: assert (len_o == LEN_W'(ESC_LEN))
        else $error("escape codeword length wrong");
    end
  end

  // Level code, signed value, suffix length adaptation
  always_comb begin
    lc = (LC_W'(pfx) << sl_i) + LC_W'(suf);
    if (pfx == PFX_ESC && sl_i == '0) lc = lc + LC_W'(15);
    if (bump_i)                      lc = lc + LC_W'(2);
    mag     = lc[0] ? ((lc + LC_W'(1)) >> 1) : ((lc + LC_W'(2)) >> 1);
    level_o = lc[0] ? -LVL_W'(mag) : LVL_W'(mag);
    sl_eff  = (sl_i == '0) ? SL_W'(1) : sl_i;
    thr     = LC_W'(3) << (sl_eff - SL_W'(1));
    if (mag > thr && sl_eff < SL_W'(SL_CAP)) sl_next_o = sl_eff + SL_W'(1);
    else                                     sl_next_o = sl_eff;
    assert_sl_cap_R9: assert (sl_next_o <= SL_W'(SL_CAP))
      else $error("suffix length above cap");
  end

endmodule

// File: rtl/lvl_seq_ctrl.sv
module lvl_seq_ctrl
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned LVL_W = 16,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LEN_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         tc_i,
  input  logic [1:0]               t1_i,
  input  logic [CNT_W-1:0]         mx_i,
  input  logic [T1_MAX-1:0]        win_top_i,
  input  logic [T1_MAX-1:0]        sign_we_i,
  input  logic [T1_MAX*LVL_W-1:0]  sign_data_i,
  input  logic [LVL_W-1:0]         level_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [SL_W-1:0]          sl_next_i,
  output logic [T1_MAX-1:0]        sign_q_o,
  output logic [1:0]               t1_q_o,
  output logic [SL_W-1:0]          sl_q_o,
  output logic                     bump_q_o,
  output logic [LEN_W-1:0]         consume_len_o,
  output logic [T1_MAX-1:0]        wr_en_o,
  output logic [IDX_W-1:0]         wr_idx_o,
  output logic [T1_MAX*LVL_W-1:0]  wr_data_o,
  output logic                     done_o,
  output logic                     skip_tz_o,
  output logic                     zero_blk_o
);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  tc_q;
  logic [1:0]        t1_q;
  logic              skip_q;
  logic [T1_MAX-1:0] sign_q;
  logic [SL_W-1:0]   sl_q, sl_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              bump_q, bump_d;
  logic              ld_start, en_walk, last;

  assign ld_start = (state_q == ST_IDLE) && start_i;
  assign en_walk  = (state_q == ST_SIGN) || (state_q == ST_LEVEL);

  // Final-write detection per state
  always_comb begin
    unique case (state_q)
      ST_ZERO:  last = 1'b1;
      ST_SIGN:  last = (tc_q == CNT_W'(t1_q));
      ST_LEVEL: last = ((CNT_W'(idx_q) + CNT_W'(1)) == tc_q);
      default:  last = 1'b0;
    endcase
  end

  // Next state and walk registers
  always_comb begin
    state_d = state_q;
    sl_d    = sl_q;
    idx_d   = idx_q;
    bump_d  = bump_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = (tc_i == '0) ? ST_ZERO : ST_SIGN;
          sl_d    = (tc_i > CNT_W'(10) && t1_i < 2'd3) ? SL_W'(1) : SL_W'(0);
          idx_d   = '0;
          bump_d  = (t1_i < 2'd3);
        end
      end
      ST_ZERO: state_d = ST_IDLE;
      ST_SIGN: begin
        idx_d   = IDX_W'(t1_q);
        state_d = last ? ST_IDLE : ST_LEVEL;
      end
      ST_LEVEL: begin
        idx_d   = idx_q + IDX_W'(1);
        sl_d    = sl_next_i;
        bump_d  = 1'b0;
        state_d = last ? ST_IDLE : ST_LEVEL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= '0;
      t1_q   <= '0;
      skip_q <= 1'b0;
      sign_q <= '0;
    end else if (ld_start) begin
      tc_q   <= tc_i;
      t1_q   <= t1_i;
      skip_q <= (tc_i == '0) || (tc_i == mx_i);
      sign_q <= win_top_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sl_q   <= '0;
      idx_q  <= '0;
      bump_q <= 1'b0;
    end else if (ld_start || en_walk) begin
      sl_q   <= sl_d;
      idx_q  <= idx_d;
      bump_q <= bump_d;
    end
  end

  // Output steering
  always_comb begin
    consume_len_o = '0;
    wr_en_o       = '0;
    wr_idx_o      = '0;
    wr_data_o     = '0;
    unique case (state_q)
      ST_SIGN: begin
        consume_len_o = LEN_W'(t1_q);
        wr_en_o       = sign_we_i;
        wr_data_o     = sign_data_i;
      end
      ST_LEVEL: begin
        consume_len_o = len_i;
        wr_en_o       = T1_MAX'(1);
        wr_idx_o      = idx_q;
        wr_data_o     = {{((T1_MAX-1)*LVL_W){1'b0}}, level_i};
      end
      default: ;
    endcase
  end

  assign done_o     = last;
  assign skip_tz_o  = last && skip_q;
  assign zero_blk_o = (state_q == ST_ZERO);

  assign sign_q_o = sign_q;
  assign t1_q_o   = t1_q;
  assign sl_q_o   = sl_q;
  assign bump_q_o = bump_q;

  // R10: done lasts exactly one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2: an empty block writes and consumes nothing and flags both skips
  assert_zero_flags_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    zero_blk_o |-> (done_o && skip_tz_o && wr_en_o == '0 && consume_len_o == '0));

  // R4: the write index continues from the entries already written
  assert_idx_order_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_o[0] && !done_o) |=>
      (wr_idx_o == IDX_W'($past(wr_idx_o) + IDX_W'($countones($past(wr_en_o))))));

  // R7: no single cycle consumes more than an escape codeword
  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    consume_len_o <= LEN_W'(ESC_LEN));

  // R9: stored suffix length never passes the cap
  assert_sl_reg_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    sl_q <= SL_W'(SL_CAP));

endmodule

// File: rtl/cavlc_level_dec.sv
module cavlc_level_dec
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned WIN_W     = 32,
  parameter int unsigned LVL_W     = 16,
  parameter int unsigned MAX_COEFF = 16,
  // derived widths; keep at their defaults
  parameter int unsigned CNT_W     = $clog2(MAX_COEFF + 1),
  parameter int unsigned IDX_W     = $clog2(MAX_COEFF),
  parameter int unsigned LEN_W     = $clog2(WIN_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        total_coeff,
  input  logic [1:0]              trailing_ones,
  input  logic [CNT_W-1:0]        max_coeff,
  input  logic [WIN_W-1:0]        bits,
  output logic [LEN_W-1:0]        consume_len,
  output logic [T1_MAX-1:0]       wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [T1_MAX*LVL_W-1:0] wr_data,
  output logic                    done,
  output logic                    skip_tz,
  output logic                    zero_blk
);

  logic [1:0]               rst_pipe;
  logic                     rst_q;
  logic [T1_MAX-1:0]        sign_q;
  logic [1:0]               t1_q;
  logic [SL_W-1:0]          sl_q, sl_next;
  logic                     bump_q;
  logic [T1_MAX-1:0]        sign_we;
  logic [T1_MAX*LVL_W-1:0]  sign_data;
  logic [LVL_W-1:0]         level;
  logic [LEN_W-1:0]         len;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  t1_sign_unit #(.LVL_W(LVL_W)) u_sign (
    .sign_i (sign_q),
    .t1_i   (t1_q),
    .we_o   (sign_we),
    .data_o (sign_data)
  );

  level_code_unit #(.WIN_W(WIN_W), .LVL_W(LVL_W), .LEN_W(LEN_W)) u_level (
    .win_i     (bits),
    .sl_i      (sl_q),
    .bump_i    (bump_q),
    .level_o   (level),
    .len_o     (len),
    .sl_next_o (sl_next)
  );

  lvl_seq_ctrl #(.LVL_W(LVL_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rst_ni        (rst_q),
    .start_i       (start),
    .tc_i          (total_coeff),
    .t1_i          (trailing_ones),
    .mx_i          (max_coeff),
    .win_top_i     (bits[WIN_W-1 -: T1_MAX]),
    .sign_we_i     (sign_we),
    .sign_data_i   (sign_data),
    .level_i       (level),
    .len_i         (len),
    .sl_next_i     (sl_next),
    .sign_q_o      (sign_q),
    .t1_q_o        (t1_q),
    .sl_q_o        (sl_q),
    .bump_q_o      (bump_q),
    .consume_len_o (consume_len),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .wr_data_o     (wr_data),
    .done_o        (done),
    .skip_tz_o     (skip_tz),
    .zero_blk_o    (zero_blk)
  );

endmodule

// File: tb/tb_cavlc_level_dec.sv
module tb_cavlc_level_dec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [4:0]  total_coeff;
  logic [1:0]  trailing_ones;
  logic [4:0]  max_coeff;
  logic [31:0] bits;
  logic [5:0]  consume_len;
  logic [2:0]  wr_en;
  logic [3:0]  wr_idx;
  logic [47:0] wr_data;
  logic        done, skip_tz, zero_blk;

  int nchk = 0;
  int errs = 0;

  logic [511:0] stream;
  int sp, pos;
  int lvq[16];
  int lens[16];

  always #2 clk = ~clk;  // 250 MHz

  cavlc_level_dec dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_coeff(total_coeff),
    .trailing_ones(trailing_ones), .max_coeff(max_coeff), .bits(bits),
    .consume_len(consume_len), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done), .skip_tz(skip_tz), .zero_blk(zero_blk)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic put(input int val, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      stream[511 - sp] = val[b];
      sp++;
    end
  endtask

  task automatic set_win();
    logic [511:0] tmp;
    tmp  = stream << pos;
    bits = tmp[511:480];
  endtask

  // Forward coder for one level, following the requirement text
  task automatic encode_level(input int lv, inout int sl, input bit bump, output int ln);
    int lc, p, mag;
    lc = (lv > 0) ? 2 * lv - 2 : -2 * lv - 1;
    if (bump) lc = lc - 2;                               // R8
    if (sl == 0) begin
      if (lc < 14)      begin put(1, lc + 1); ln = lc + 1; end
      else if (lc < 30) begin put(1, 15); put(lc - 14, 4); ln = 19; end      // R6
      else              begin put(1, 16); put(lc - 30, 12); ln = 28; end     // R7
    end else begin
      if (lc < (15 << sl)) begin
        p = lc >> sl;
        put(1, p + 1); put(lc & ((1 << sl) - 1), sl); ln = p + 1 + sl;
      end else begin
        put(1, 16); put(lc - (15 << sl), 12); ln = 28;                       // R7
      end
    end
    if (sl == 0) sl = 1;                                 // R9
    mag = (lv < 0) ? -lv : lv;
    if (mag > (3 << (sl - 1)) && sl < 6) sl++;
  endtask

  task automatic run_block(input int tc, input int t1, input int mx,
                           input logic [2:0] sg, input int nlv);
    int sl;
    bit exp_skip;
    stream = '0; sp = 0; pos = 0;
    for (int k = 0; k < t1; k++) put(int'(sg[2-k]), 1);
    sl = (tc > 10 && t1 < 3) ? 1 : 0;
    for (int i = 0; i < nlv; i++) encode_level(lvq[i], sl, (i == 0) && (t1 < 3), lens[i]);
    put(7, 3);  // filler ones, must not be read as signs
    set_win();
    exp_skip = (tc == 0) || (tc == mx);
    total_coeff = 5'(tc); trailing_ones = 2'(t1); max_coeff = 5'(mx); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (tc == 0) begin
      @(negedge clk);
      chk(done == 1'b1,     "R2 done on empty block", int'(done), 1);
      chk(zero_blk == 1'b1, "R2 zero_blk", int'(zero_blk), 1);
      chk(skip_tz == 1'b1,  "R2 skip_tz", int'(skip_tz), 1);
      chk(wr_en == 3'b000,  "R2 no writes", int'(wr_en), 0);
      chk(consume_len == 0, "R2 no bits consumed", int'(consume_len), 0);
      @(posedge clk); #1;
      @(negedge clk);
      chk(done == 1'b0, "R10 done single pulse", int'(done), 0);
      return;
    end
    // sign cycle
    @(negedge clk);
    chk(int'(consume_len) == t1, "R3 sign consume", int'(consume_len), t1);
    chk(int'(wr_en) == ((1 << t1) - 1), "R3 sign write mask", int'(wr_en), (1 << t1) - 1);
    chk(wr_idx == 4'd0, "R3 sign base index", int'(wr_idx), 0);
    for (int k = 0; k < t1; k++)
      chk(int'($signed(wr_data[k*16 +: 16])) == (sg[2-k] ? -1 : 1), "R3 sign value",
          int'($signed(wr_data[k*16 +: 16])), sg[2-k] ? -1 : 1);
    chk(done == (tc == t1), "R10 done in sign cycle", int'(done), int'(tc == t1));
    if (tc == t1) chk(skip_tz == exp_skip, "R10 skip_tz", int'(skip_tz), int'(exp_skip));
    chk(zero_blk == 1'b0, "R2 zero_blk low on nonempty", int'(zero_blk), 0);
    @(posedge clk); #1 pos += t1; set_win();
    for (int i = 0; i < nlv; i++) begin
      @(negedge clk);
      chk(wr_en == 3'b001, "R4 one level per cycle", int'(wr_en), 1);
      chk(int'(wr_idx) == t1 + i, "R4 decode order index", int'(wr_idx), t1 + i);
      chk(int'($signed(wr_data[15:0])) == lvq[i], "R5/R8/R9 level value",
          int'($signed(wr_data[15:0])), lvq[i]);
      chk(int'(consume_len) == lens[i], "R4/R6/R7 consumed length", int'(consume_len), lens[i]);
      chk(done == (i == nlv - 1), "R10 done on last level", int'(done), int'(i == nlv - 1));
      if (i == nlv - 1) chk(skip_tz == exp_skip, "R10 skip_tz", int'(skip_tz), int'(exp_skip));
      @(posedge clk); #1 pos += lens[i]; set_win();
    end
    @(negedge clk);
    chk(done == 1'b0 && wr_en == 3'b000, "R10 idle after done", int'(done), 0);
  endtask

  task automatic clear_lvq();
    for (int i = 0; i < 16; i++) lvq[i] = 0;
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; total_coeff = '0; trailing_ones = '0;
    max_coeff = 5'd16; bits = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_en == 3'b000 && done == 1'b0, "R1 quiet in reset", int'(wr_en), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(consume_len == 0, "R1 consume after reset", int'(consume_len), 0);
    chk(done == 1'b0 && skip_tz == 1'b0, "R1 done/skip after reset", int'(done), 0);
    chk(zero_blk == 1'b0 && wr_en == 3'b000, "R1 zero_blk/writes after reset", int'(zero_blk), 0);
    @(posedge clk); #1;
  endtask

  // R2
  task automatic t_zero();
    clear_lvq();
    run_block(0, 0, 16, 3'b000, 0);
  endtask

  // R3, R10: all trailing ones, no levels, skip_tz low
  task automatic t_signs_only();
    clear_lvq();
    run_block(3, 3, 16, 3'b101, 0);
  endtask

  // R3: two signs, third bit masked; R10: tc equals max
  task automatic t_signs_mask();
    clear_lvq();
    run_block(2, 2, 2, 3'b010, 0);
  endtask

  // R4, R5, R8: small levels, bump on the first
  task automatic t_small();
    clear_lvq();
    lvq[0] = 3; lvq[1] = -2; lvq[2] = 1; lvq[3] = -1;
    run_block(5, 1, 16, 3'b100, 4);
  endtask

  // R6: prefix 14 with suffix length 0, no bump (three trailing ones); R10 skip
  task automatic t_prefix14();
    clear_lvq();
    lvq[0] = -10;
    run_block(4, 3, 4, 3'b000, 1);
  endtask

  // R7: escape with suffix length 0 and bump, then a short code
  task automatic t_escape0();
    clear_lvq();
    lvq[0] = 20; lvq[1] = -5;
    run_block(2, 0, 15, 3'b000, 2);
  endtask

  // R9: initial suffix length 1, growth to the cap, escapes at larger lengths
  task automatic t_grow();
    clear_lvq();
    lvq[0] = 100; lvq[1] = 200; lvq[2] = 300; lvq[3] = 400; lvq[4] = 500;
    lvq[5] = 600; lvq[6] = -700; lvq[7] = 50; lvq[8] = 1; lvq[9] = -1; lvq[10] = 2;
    run_block(12, 1, 16, 3'b100, 11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog R4: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_signs_only();
    t_signs_mask();
    t_small();
    t_prefix14();
    t_escape0();
    t_grow();
    t_small();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

endmodule